// File: doc/BRIEF.md
# Configurable CAN Identifier Acceptance Filter

This block screens the identifier bytes of each received CAN frame against one shared bank of acceptance code and mask bits, 64 bits of each. A 2-bit mode input splits the bank into two 32-bit filters, four 16-bit filters or eight 8-bit filters, or closes the filter so that nothing is accepted. Frame decoding, CRC and bit timing live upstream. This block sees one frame at a time as an identifier word, a frame tag and a valid strobe. One cycle later it answers with an accept or a reject pulse.

An accepted frame enters a 4-entry receive queue together with the index of the filter that matched it. When several filters match, the lowest-numbered one wins. The status output `hit_o` always describes the frame at the head of the queue. It is loaded on the clock edge at which a frame becomes the head. A frame that arrives when the queue is full is dropped, and a sticky overrun flag is set. The host removes the head with a one-cycle pop pulse.

Top module: `can_accept_filter`

## Requirements
- R1: Mode 2'b00 forms two 32-bit filters. Filter f compares identifier bits [31:0] with bank bits [32f+31:32f].
- R2: Mode 2'b01 forms four 16-bit filters. Filter f compares identifier bits [15:0] with bank bits [16f+15:16f], and identifier bits [31:16] are ignored.
- R3: Mode 2'b10 forms eight 8-bit filters. Filter f compares identifier bits [7:0] with bank bits [8f+7:8f], and identifier bits [31:8] are ignored.
- R4: Mode 2'b11 rejects every frame, and no entry is added to the receive queue.
- R5: A mask bit of 1 excludes that bank bit from comparison. A filter matches when every compared bit of the code equals the identifier bit.
- R6: When several filters match, the hit index is the binary number (0 to 7) of the lowest-numbered matching filter.
- R7: `accept_o` or `reject_o` pulses for exactly one cycle, in the cycle after `frm_valid_i`, and never both at once. `accept_o` reports the filter verdict even when the queue is full.
- R8: `hit_o` and `head_tag_o` describe the queue head. They load on the edge at which a frame becomes the head, and `hit_o` holds while the head is neither popped nor replaced.
- R9: A pop pulse removes the head. The next entry's hit index and tag appear in the following cycle. A pop and a push in the same cycle on a one-entry queue make the pushed frame the head. A pop on an empty queue has no effect.
- R10: The queue holds 4 entries in arrival order. An accepted frame that arrives while the queue is full and no pop occurs is dropped, and `overrun_o` is set until reset.
- R11: Changing the mode leaves the hit indices of already-queued entries unchanged.
- R12: After reset, `accept_o`, `reject_o`, `head_valid_o`, `overrun_o` and `hit_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Filter organisation: 00 two 32-bit, 01 four 16-bit, 10 eight 8-bit, 11 closed |
| code_i | input | 64 | Acceptance code bank |
| mask_i | input | 64 | Acceptance mask bank (1 = ignore bit) |
| frm_valid_i | input | 1 | Identifier and tag are valid this cycle |
| frm_id_i | input | 32 | Identifier bytes of the received frame |
| frm_tag_i | input | TAG_W | Tag stored with an accepted frame |
| pop_i | input | 1 | Release the queue head (one-cycle pulse) |
| accept_o | output | 1 | Frame matched a filter (one cycle after valid) |
| reject_o | output | 1 | Frame matched no filter (one cycle after valid) |
| head_valid_o | output | 1 | Queue holds at least one entry |
| head_tag_o | output | TAG_W | Tag of the head entry |
| hit_o | output | 3 | Index of the filter that matched the head entry |
| overrun_o | output | 1 | Sticky: an accepted frame was dropped on a full queue |

## Verification
In the 8-bit organisation the low identifier byte is swept over all 256 values while the upper bytes are random, against a bank where some lanes overlap and one lane is fully masked. This sweep separates priority faults from lane-mapping faults. The 16-bit and 32-bit organisations receive pseudo-random identifiers, and every fourth of them is aimed at a chosen filter with random bits only under the mask. These frames show whether the bank slicing, the mask polarity and the filter width are right. The closed organisation receives random identifiers that must all be refused. A separate queue sequence fills the queue past capacity, changes the mode and then drains it. This shows whether the hit index follows the head rather than the newest arrival, whether overrun is sticky and whether stored hits survive a mode change.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 8;
  localparam int ID_LANES  = 4;
  localparam int BANK_W    = NUM_LANES * LANE_W;
  localparam int ID_W      = ID_LANES * LANE_W;
  localparam int HIT_W     = $clog2(NUM_LANES);

  typedef enum logic [1:0] {
    FM_WIDE32 = 2'b00,
    FM_MID16  = 2'b01,
    FM_NARROW = 2'b10,
    FM_CLOSED = 2'b11
  } filt_mode_e;
endpackage

// File: rtl/cf_match_bank.sv
module cf_match_bank #(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int ID_LANES = 4
) (
  input  logic [1:0]                 mode_i,
  input  logic [LANES*LANE_W-1:0]    code_i,
  input  logic [LANES*LANE_W-1:0]    mask_i,
  input  logic [ID_LANES*LANE_W-1:0] id_i,
  output logic [LANES-1:0]           match_o
);
  import can_filt_pkg::*;

  localparam int N32 = LANES / 4;
  localparam int N16 = LANES / 2;

  // per-lane equality, with the identifier lane chosen by filter width
  logic [LANES-1:0] eq_w4, eq_w2, eq_w1;
  logic [LANES-1:0] m32, m16, m8;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] lane_code, lane_mask;
    assign lane_code = code_i[j*LANE_W +: LANE_W];
    assign lane_mask = mask_i[j*LANE_W +: LANE_W];
    assign eq_w4[j] = ~|((lane_code ^ id_i[(j%4)*LANE_W +: LANE_W]) & ~lane_mask);
    assign eq_w2[j] = ~|((lane_code ^ id_i[(j%2)*LANE_W +: LANE_W]) & ~lane_mask);
    assign eq_w1[j] = ~|((lane_code ^ id_i[0 +: LANE_W]) & ~lane_mask);
  end

  for (genvar f = 0; f < LANES; f++) begin : g_filt
    if (f < N32) begin : g_f32
      assign m32[f] = &eq_w4[4*f +: 4];
    end else begin : g_n32
      assign m32[f] = 1'b0;
    end
    if (f < N16) begin : g_f16
      assign m16[f] = &eq_w2[2*f +: 2];
    end else begin : g_n16
      assign m16[f] = 1'b0;
    end
    assign m8[f] = eq_w1[f];
  end

  always_comb begin
    case (filt_mode_e'(mode_i))
      FM_WIDE32: match_o = m32;
      FM_MID16:  match_o = m16;
      FM_NARROW: match_o = m8;
      default:   match_o = '0;
    endcase
  end
endmodule

// File: rtl/cf_prio_enc.sv
module cf_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cf_rx_queue.sv
module cf_rx_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  parameter int HIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic [HIT_W-1:0] push_hit_i,
  input  logic             pop_i,
  output logic             head_valid_o,
  output logic [TAG_W-1:0] head_tag_o,
  output logic [HIT_W-1:0] head_hit_o,
  output logic             drop_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [HIT_W-1:0] hit_mem [DEPTH];

  logic [AW-1:0]    rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [HIT_W-1:0] hit_q, hit_n;
  logic             do_pop, do_push;

  always_comb begin
    do_pop  = pop_i && (cnt_q != '0);
    do_push = push_i && ((cnt_q != FULL_CNT) || do_pop);
    drop_o  = push_i && !do_push;

    rd_n  = do_pop  ? AW'(rd_q + 1'b1) : rd_q;
    wr_n  = do_push ? AW'(wr_q + 1'b1) : wr_q;
    cnt_n = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;

    // head hit changes only when a new entry becomes the head
    hit_n = hit_q;
    if (do_pop) begin
      if (cnt_q > CW'(1))  hit_n = hit_mem[AW'(rd_q + 1'b1)];
      else if (do_push)    hit_n = push_hit_i;
    end else if ((cnt_q == '0) && do_push) begin
      hit_n = push_hit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      hit_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
      hit_q <= hit_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      tag_mem[wr_q] <= push_tag_i;
      hit_mem[wr_q] <= push_hit_i;
    end
  end

  assign head_valid_o = (cnt_q != '0);
  assign head_tag_o   = tag_mem[rd_q];
  assign head_hit_o   = hit_q;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [BANK_W-1:0] code_i,
  input  logic [BANK_W-1:0] mask_i,
  input  logic              frm_valid_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic [TAG_W-1:0]  frm_tag_i,
  input  logic              pop_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic              head_valid_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [HIT_W-1:0]  hit_o,
  output logic              overrun_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [NUM_LANES-1:0] match;
  logic                 any_hit;
  logic [HIT_W-1:0]     hit_idx;
  logic                 q_drop;
  logic                 acc_n, rej_n, ovr_n;
  logic                 acc_q, rej_q, ovr_q;

  cf_match_bank #(
    .LANES(NUM_LANES), .LANE_W(LANE_W), .ID_LANES(ID_LANES)
  ) u_bank (
    .mode_i (mode_i),
    .code_i (code_i),
    .mask_i (mask_i),
    .id_i   (frm_id_i),
    .match_o(match)
  );

  cf_prio_enc #(.N(NUM_LANES), .IW(HIT_W)) u_prio (
    .req_i(match),
    .any_o(any_hit),
    .idx_o(hit_idx)
  );

  cf_rx_queue #(.DEPTH(QDEPTH), .TAG_W(TAG_W), .HIT_W(HIT_W)) u_queue (
    .clk         (clk),
    .rst_n       (rst_s2_q),
    .push_i      (frm_valid_i && any_hit),
    .push_tag_i  (frm_tag_i),
    .push_hit_i  (hit_idx),
    .pop_i       (pop_i),
    .head_valid_o(head_valid_o),
    .head_tag_o  (head_tag_o),
    .head_hit_o  (hit_o),
    .drop_o      (q_drop)
  );

  always_comb begin
    acc_n = frm_valid_i && any_hit;
    rej_n = frm_valid_i && !any_hit;
    ovr_n = ovr_q || q_drop;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      rej_q <= rej_n;
      ovr_q <= ovr_n;
    end
  end

  assign accept_o  = acc_q;
  assign reject_o  = rej_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/cf_checker.sv
module cf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       frm_valid_i,
  input logic       pop_i,
  input logic       accept_o,
  input logic       reject_o,
  input logic       head_valid_o,
  input logic [2:0] hit_o,
  input logic       overrun_o
);
  assert_closed_rejects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && mode_i == 2'b11) |=> (reject_o && !accept_o));

  assert_closed_no_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_valid_o && (mode_i == 2'b11 || !frm_valid_i)) |=> !head_valid_o);

  assert_verdict_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && reject_o));

  assert_no_frame_no_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid_i |=> (!accept_o && !reject_o));

  assert_hit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid_o && !pop_i) |=> $stable(hit_o));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
endmodule

bind can_accept_filter cf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .frm_valid_i (frm_valid_i),
  .pop_i       (pop_i),
  .accept_o    (accept_o),
  .reject_o    (reject_o),
  .head_valid_o(head_valid_o),
  .hit_o       (hit_o),
  .overrun_o   (overrun_o)
);

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [63:0] code, mask;
  logic        fv;
  logic [31:0] fid;
  logic [7:0]  ftag;
  logic        pop;
  logic        acc, rej, hv, ovr;
  logic [7:0]  htag;
  logic [2:0]  hit;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  can_accept_filter uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .code_i(code), .mask_i(mask),
    .frm_valid_i(fv), .frm_id_i(fid), .frm_tag_i(ftag), .pop_i(pop),
    .accept_o(acc), .reject_o(rej), .head_valid_o(hv), .head_tag_o(htag),
    .hit_o(hit), .overrun_o(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // reference: {valid, index}, lowest-numbered match wins
  function automatic logic [3:0] ref_hit(input logic [1:0] m, input logic [63:0] c,
                                         input logic [63:0] k, input logic [31:0] id);
    int nf, w;
    logic [3:0] r;
    r  = 4'b0;
    nf = (m == 2'd0) ? 2 : (m == 2'd1) ? 4 : (m == 2'd2) ? 8 : 0;
    w  = (nf == 0) ? 0 : 64 / nf;
    for (int f = nf - 1; f >= 0; f--) begin
      logic ok;
      ok = 1'b1;
      for (int b = 0; b < w; b++)
        if (!k[f*w+b] && (c[f*w+b] != id[b])) ok = 1'b0;
      if (ok) r = {1'b1, 3'(f)};
    end
    return r;
  endfunction

  task automatic send(input logic [31:0] id, input logic [7:0] tag);
    @(negedge clk);
    fv = 1'b1; fid = id; ftag = tag;
    @(negedge clk);
    fv = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  // one frame through an empty queue, checked and drained
  task automatic run_frame(input string req, input logic [31:0] id, input logic [7:0] tag);
    logic [3:0] e;
    e = ref_hit(mode, code, mask, id);
    send(id, tag);
    chk({req, " R7 accept"}, 32'(acc), 32'(e[3]));
    chk({req, " R7 reject"}, 32'(rej), 32'(!e[3]));
    chk({req, " R4 head"}, 32'(hv), 32'(e[3]));
    if (e[3]) begin
      chk({req, " R6 R8 hit"}, 32'(hit), 32'(e[2:0]));
      chk({req, " R8 tag"}, 32'(htag), 32'(tag));
      do_pop();
      chk({req, " R9 drained"}, 32'(hv), 32'd0);
    end
  endtask

  task automatic sweep(input string req, input logic [1:0] m, input int n);
    int nf, w;
    mode = m;
    nf = (m == 2'd0) ? 2 : (m == 2'd1) ? 4 : 8;
    w  = 64 / nf;
    for (int i = 0; i < n; i++) begin
      logic [31:0] id, r;
      id = rnd();
      if (i % 4 == 1) begin
        int f;
        f = (i / 4) % nf;
        r = rnd();
        for (int b = 0; b < w; b++) id[b] = code[f*w+b] ^ (r[b] & mask[f*w+b]);
      end
      run_frame(req, id, 8'(i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; code = '0; mask = '0;
    fv = 1'b0; fid = '0; ftag = '0; pop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 accept", 32'(acc), 0);
    chk("R12 reject", 32'(rej), 0);
    chk("R12 head", 32'(hv), 0);
    chk("R12 overrun", 32'(ovr), 0);
    chk("R12 hit", 32'(hit), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R5 R6: exhaustive low byte, overlapping and masked lanes
    mode = 2'b10;
    code = 64'hF0_3C_A5_5A_00_FF_81_7E;
    mask = 64'h0F_00_00_0F_FF_00_10_00;
    for (int i = 0; i < 256; i++)
      run_frame("R3 R5", {rnd()[31:8], 8'(i)}, 8'(i));

    // R2 R5 R6
    code = 64'h1234_ABCD_0F0F_8001;
    mask = 64'h00FF_0000_F0F0_0000;
    sweep("R2 R5", 2'b01, 300);

    // R1 R5 R6
    code = 64'hDEADBEEF_CAFE0000;
    mask = 64'h0000FFFF_000000FF;
    sweep("R1 R5", 2'b00, 300);

    // R4: closed, even with an all-ignore mask
    mask = '1;
    mode = 2'b11;
    for (int i = 0; i < 64; i++) run_frame("R4 closed", rnd(), 8'(i));

    // R8 R9 R10 R11: queue behaviour in 8-bit mode, lane f = 8'h11*f
    mode = 2'b10;
    code = 64'h77_66_55_44_33_22_11_00;
    mask = '0;
    send(32'h22, 8'hA0);
    chk("R9 single head hit", 32'(hit), 2);
    @(negedge clk);
    pop = 1'b1; fv = 1'b1; fid = 32'h66; ftag = 8'hA1;
    @(negedge clk);
    pop = 1'b0; fv = 1'b0;
    chk("R9 pop+push hit", 32'(hit), 6);
    chk("R9 pop+push tag", 32'(htag), 32'hA1);
    do_pop();
    chk("R9 empty", 32'(hv), 0);
    do_pop();
    chk("R9 pop empty ignored", 32'(hv), 0);
    chk("R9 pop empty no overrun", 32'(ovr), 0);

    send(32'h22, 8'hB0);
    chk("R8 first head", 32'(hit), 2);
    send(32'h55, 8'hB1);
    chk("R8 head kept", 32'(hit), 2);
    send(32'h00, 8'hB2);
    send(32'h77, 8'hB3);
    chk("R8 head kept full", 32'(hit), 2);
    chk("R10 no overrun yet", 32'(ovr), 0);
    send(32'h33, 8'hB4);
    chk("R7 accept on full", 32'(acc), 1);
    chk("R10 overrun set", 32'(ovr), 1);
    chk("R10 head unchanged", 32'(htag), 32'hB0);

    mode = 2'b11;
    do_pop();
    chk("R11 hit 2nd", 32'(hit), 5);
    chk("R10 tag 2nd", 32'(htag), 32'hB1);
    mode = 2'b00;
    do_pop();
    chk("R11 hit 3rd", 32'(hit), 0);
    chk("R10 tag 3rd", 32'(htag), 32'hB2);
    do_pop();
    chk("R11 hit 4th", 32'(hit), 7);
    chk("R10 tag 4th", 32'(htag), 32'hB3);
    do_pop();
    chk("R10 dropped frame absent", 32'(hv), 0);
    chk("R10 overrun sticky", 32'(ovr), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule